// File: doc/BRIEF.md
# Overlapped Translation and Cache Lookup

This block serves loads and stores from a 4 KB direct-mapped data cache of 32-bit lines. The cache is indexed by the virtual address and tagged by the physical address. The line index and byte offset lie entirely inside the untranslated 12-bit page displacement. The cache array can therefore be read in the same cycle that a small fully associative translation buffer searches for the 20-bit virtual page number. A single comparison then decides the outcome: the stored line tag against the physical page number the translation produced.

A request is a valid/ready transfer carrying a virtual address, a store flag and store data. One cycle after acceptance, a response is presented on a valid/ready channel. The response reports exactly one of four outcomes: hit (with line data), memory request (with the physical address to fetch), protection fault, or translation miss. When no response is pending or the pending one is being taken in the same cycle, `req_ready` is high. While `resp_valid` is high and `resp_ready` is low, the response holds still and no new request is accepted.

Translation entries are written through a plain write port. Page-table walking is left to the surrounding logic, which learns of it through the translation-miss outcome. Cache lines are installed through a plain fill port by the memory side.

Top module: `vipt_lookup`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and its response appears with `resp_valid` high after that edge. `req_ready` equals `!resp_valid || resp_ready`. A response held by low `resp_ready` keeps every field unchanged.
- R2: When no valid translation entry holds the virtual page number (address bits 31:12), the response has `resp_tlb_miss`=1, and hit, fault and memory request are all 0. `resp_paddr`, `resp_data` and both previous-state flags are 0.
- R3: With a translation hit, a permitted access and a valid line at index `vaddr[11:2]` whose tag equals the physical page number, the response has `resp_hit`=1. `resp_data` carries the line content, and `resp_paddr` = {physical page, `vaddr[11:0]`}.
- R4: With a translation hit and a permitted access, a line that is invalid or has a different tag gives `resp_mem_req`=1 with `resp_paddr` = {physical page, `vaddr[11:0]`} and `resp_data`=0.
- R5: A load needs the entry's read right and a store needs its write right. Without the right, the response has `resp_prot_fault`=1, with no hit, no memory request and `resp_data`=0, and `resp_paddr` still gives the translation.
- R6: `resp_ref_prev` gives the matched entry's referenced flag as it was before the access. Every accepted access that hits in the translation buffer sets that flag.
- R7: `resp_dirty_prev` gives the matched entry's dirty flag as it was before the access. A permitted store sets it, and a faulting store leaves it unchanged.
- R8: A permitted store that hits replaces the line data with `req_wdata`, and its response carries the line content from before the store. A store that misses or faults leaves the line unchanged.
- R9: A translation write whose virtual page is already present rewrites that entry in place and does not advance the victim pointer. Otherwise it writes the entry under a round-robin pointer that starts at entry 0 after reset and steps once per such write. A written entry starts with the referenced and dirty flags clear.
- R10: A fill writes the line at `fill_paddr[11:2]` with tag `fill_paddr[31:12]` and marks it valid. Reset invalidates every line and every translation entry.
- R11: Two virtual pages mapped to the same physical page share the cache line selected by the displacement. A line filled for one alias hits through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_hit | output | 1 | Cache hit outcome |
| resp_tlb_miss | output | 1 | Translation miss outcome |
| resp_prot_fault | output | 1 | Access-right violation outcome |
| resp_mem_req | output | 1 | Cache miss, memory access needed |
| resp_paddr | output | 32 | Translated physical address (0 on translation miss) |
| resp_data | output | 32 | Line data on hit, else 0 |
| resp_ref_prev | output | 1 | Referenced flag before this access |
| resp_dirty_prev | output | 1 | Dirty flag before this access |
| tlb_wr_en | input | 1 | Write a translation entry |
| tlb_wr_vpn | input | 20 | Virtual page number to write |
| tlb_wr_ppn | input | 20 | Physical page number to write |
| tlb_wr_rd_ok | input | 1 | Read right of the written page |
| tlb_wr_wr_ok | input | 1 | Write right of the written page |
| fill_en | input | 1 | Install a cache line |
| fill_paddr | input | 32 | Physical address of the line |
| fill_data | input | 32 | Line data |

## Verification
The bench targets aliasing. Two virtual pages share one physical page, so a design that indexed or tagged with the virtual page number would miss where it should hit. It targets a line that is valid but holds a foreign physical page, which a design comparing only the index or the valid bit would report as a hit. It checks stores without write rights: a design that ignored rights would overwrite the line and set the dirty flag. It exercises victim selection through eviction order and in-place rewrites. A pointer that also advanced on rewrites would evict the wrong page.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } rights_t;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb
  import vipt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output rights_t          lk_rights,
  output logic             lk_ref,
  output logic             lk_dirty,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  rights_t          wr_rights
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] e_valid, e_ref, e_dirty;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];
  rights_t            e_rt  [ENTRIES];
  logic [ENTRIES-1:0] lk_match, wr_match, wr_sel;
  logic [PTR_W-1:0]   rr_ptr;
  logic               wr_present;

  assign wr_present = |wr_match;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
      assign lk_match[g] = e_valid[g] && (e_vpn[g] == lk_vpn);
      assign wr_match[g] = e_valid[g] && (e_vpn[g] == wr_vpn);
      assign wr_sel[g]   = wr_en && (wr_present ? wr_match[g]
                                                : (rr_ptr == PTR_W'(g)));
    end
  endgenerate

  assign lk_hit = |lk_match;

  always_comb begin
    lk_ppn    = '0;
    lk_rights = '0;
    lk_ref    = 1'b0;
    lk_dirty  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ppn    = lk_ppn | e_ppn[i];
        lk_rights = lk_rights | e_rt[i];
        lk_ref    = lk_ref | e_ref[i];
        lk_dirty  = lk_dirty | e_dirty[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid <= '0;
      e_ref   <= '0;
      e_dirty <= '0;
      rr_ptr  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wr_sel[i]) begin
          e_valid[i] <= 1'b1;
          e_ref[i]   <= 1'b0;
          e_dirty[i] <= 1'b0;
        end else if (lk_en && lk_match[i]) begin
          e_ref[i] <= 1'b1;
          if (lk_store && e_rt[i].wr) e_dirty[i] <= 1'b1;
        end
      end
      if (wr_en && !wr_present)
        rr_ptr <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_sel[i]) begin
        e_vpn[i] <= wr_vpn;
        e_ppn[i] <= wr_ppn;
        e_rt[i]  <= wr_rights;
      end
    end
  end

  // R9: rewrite-in-place keeps every page in at most one entry
  a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  a_r9_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rr_ptr) < ENTRIES);

  a_r6_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && lk_hit && !wr_en) |=> ((e_ref & $past(lk_match)) == $past(lk_match)));

  a_r7_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && lk_hit && lk_store && lk_rights.wr && !wr_en)
      |=> ((e_dirty & $past(lk_match)) == $past(lk_match)));
endmodule

// File: rtl/vipt_cache_array.sv
module vipt_cache_array #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              st_en,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [DATA_W-1:0] st_data,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign rd_valid = vld[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = dat_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)       vld <= '0;
    else if (fill_en) vld[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (st_en) dat_q[st_idx] <= st_data;
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
      dat_q[fill_idx] <= fill_data;
    end
  end

  a_r10_fill_installs: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (vld[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag)));
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_OFF_W  = 12,
  parameter int BYTE_OFF_W  = 2,
  parameter int DATA_W      = 32,
  parameter int TLB_ENTRIES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic                     req_store,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     resp_valid,
  input  logic                     resp_ready,
  output logic                     resp_hit,
  output logic                     resp_tlb_miss,
  output logic                     resp_prot_fault,
  output logic                     resp_mem_req,
  output logic [PA_W-1:0]          resp_paddr,
  output logic [DATA_W-1:0]        resp_data,
  output logic                     resp_ref_prev,
  output logic                     resp_dirty_prev,
  input  logic                     tlb_wr_en,
  input  logic [VA_W-PAGE_OFF_W-1:0] tlb_wr_vpn,
  input  logic [PA_W-PAGE_OFF_W-1:0] tlb_wr_ppn,
  input  logic                     tlb_wr_rd_ok,
  input  logic                     tlb_wr_wr_ok,
  input  logic                     fill_en,
  input  logic [PA_W-1:0]          fill_paddr,
  input  logic [DATA_W-1:0]        fill_data
);
  localparam int VPN_W = VA_W - PAGE_OFF_W;
  localparam int PPN_W = PA_W - PAGE_OFF_W;
  localparam int IDX_W = PAGE_OFF_W - BYTE_OFF_W;

  logic             accept;
  logic [VPN_W-1:0] va_vpn;
  logic [IDX_W-1:0] va_idx;
  logic             t_hit, t_ref, t_dirty;
  logic [PPN_W-1:0] t_ppn;
  rights_t          t_rights;
  rights_t          wr_rights;
  logic             c_valid;
  logic [PPN_W-1:0] c_tag;
  logic [DATA_W-1:0] c_data;
  logic             permit, tag_eq;
  logic             n_hit, n_fault, n_mem;
  logic [PA_W-1:0]  n_paddr;
  logic             st_en;

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign va_vpn    = req_vaddr[VA_W-1:PAGE_OFF_W];
  assign va_idx    = req_vaddr[PAGE_OFF_W-1:BYTE_OFF_W];
  assign wr_rights = '{rd: tlb_wr_rd_ok, wr: tlb_wr_wr_ok};

  vipt_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_en(accept), .lk_vpn(va_vpn), .lk_store(req_store),
    .lk_hit(t_hit), .lk_ppn(t_ppn), .lk_rights(t_rights),
    .lk_ref(t_ref), .lk_dirty(t_dirty),
    .wr_en(tlb_wr_en), .wr_vpn(tlb_wr_vpn), .wr_ppn(tlb_wr_ppn),
    .wr_rights(wr_rights)
  );

  vipt_cache_array #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(va_idx), .rd_valid(c_valid), .rd_tag(c_tag), .rd_data(c_data),
    .st_en(st_en), .st_idx(va_idx), .st_data(req_wdata),
    .fill_en(fill_en),
    .fill_idx(fill_paddr[PAGE_OFF_W-1:BYTE_OFF_W]),
    .fill_tag(fill_paddr[PA_W-1:PAGE_OFF_W]),
    .fill_data(fill_data)
  );

  // outcome: translation and array read meet here
  assign permit  = req_store ? t_rights.wr : t_rights.rd;
  assign tag_eq  = c_valid && (c_tag == t_ppn);
  assign n_hit   = t_hit && permit && tag_eq;
  assign n_fault = t_hit && !permit;
  assign n_mem   = t_hit && permit && !tag_eq;
  assign n_paddr = t_hit ? {t_ppn, req_vaddr[PAGE_OFF_W-1:0]} : '0;
  assign st_en   = accept && req_store && n_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid      <= 1'b0;
      resp_hit        <= 1'b0;
      resp_tlb_miss   <= 1'b0;
      resp_prot_fault <= 1'b0;
      resp_mem_req    <= 1'b0;
      resp_paddr      <= '0;
      resp_data       <= '0;
      resp_ref_prev   <= 1'b0;
      resp_dirty_prev <= 1'b0;
    end else if (accept) begin
      resp_valid      <= 1'b1;
      resp_hit        <= n_hit;
      resp_tlb_miss   <= !t_hit;
      resp_prot_fault <= n_fault;
      resp_mem_req    <= n_mem;
      resp_paddr      <= n_paddr;
      resp_data       <= n_hit ? c_data : '0;
      resp_ref_prev   <= t_hit && t_ref;
      resp_dirty_prev <= t_hit && t_dirty;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr)
      && $stable(resp_data) && $stable(resp_hit) && $stable(resp_tlb_miss)));

  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($countones({resp_hit, resp_tlb_miss, resp_prot_fault, resp_mem_req}) == 1));

  a_r2_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_tlb_miss) |-> (resp_paddr == '0 && resp_data == '0
      && !resp_ref_prev && !resp_dirty_prev));
endmodule

// File: tb/vipt_lookup_tb.sv
`timescale 1ns/1ps
module vipt_lookup_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_store = 0;
  logic [31:0] req_vaddr = '0, req_wdata = '0;
  logic        req_ready, resp_valid;
  logic        resp_ready = 1;
  logic        resp_hit, resp_tlb_miss, resp_prot_fault, resp_mem_req;
  logic [31:0] resp_paddr, resp_data;
  logic        resp_ref_prev, resp_dirty_prev;
  logic        tlb_wr_en = 0, tlb_wr_rd_ok = 0, tlb_wr_wr_ok = 0;
  logic [19:0] tlb_wr_vpn = '0, tlb_wr_ppn = '0;
  logic        fill_en = 0;
  logic [31:0] fill_paddr = '0, fill_data = '0;

  always #5 clk = ~clk;

  vipt_lookup u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_store(req_store), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_hit(resp_hit), .resp_tlb_miss(resp_tlb_miss),
    .resp_prot_fault(resp_prot_fault), .resp_mem_req(resp_mem_req),
    .resp_paddr(resp_paddr), .resp_data(resp_data),
    .resp_ref_prev(resp_ref_prev), .resp_dirty_prev(resp_dirty_prev),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
    .tlb_wr_rd_ok(tlb_wr_rd_ok), .tlb_wr_wr_ok(tlb_wr_wr_ok),
    .fill_en(fill_en), .fill_paddr(fill_paddr), .fill_data(fill_data)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit          m_v[8], m_rd[8], m_wr[8], m_ref[8], m_dirty[8];
  logic [19:0] m_vpn[8], m_ppn[8];
  int          m_rr;
  bit          c_v[1024];
  logic [19:0] c_tag[1024];
  logic [31:0] c_dat[1024];
  logic [19:0] vpn_pool[12];
  logic [19:0] ppn_pool[5];

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_ref[i] = 0; m_dirty[i] = 0; end
    for (int i = 0; i < 1024; i++) c_v[i] = 0;
    m_rr = 0;
  endtask

  function automatic int find_tlb(logic [19:0] vpn);
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic logic [69:0] actual_vec();
    return {resp_hit, resp_tlb_miss, resp_prot_fault, resp_mem_req,
            resp_ref_prev, resp_dirty_prev, resp_paddr, resp_data};
  endfunction

  task automatic check(string req, logic [69:0] act, logic [69:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tlb_write(logic [19:0] vpn, logic [19:0] ppn, bit rd, bit wr);
    int m;
    @(negedge clk);
    tlb_wr_en = 1; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
    tlb_wr_rd_ok = rd; tlb_wr_wr_ok = wr;
    @(negedge clk);
    tlb_wr_en = 0;
    m = find_tlb(vpn);
    if (m < 0) begin m = m_rr; m_rr = (m_rr + 1) % 8; end
    m_v[m] = 1; m_vpn[m] = vpn; m_ppn[m] = ppn; m_rd[m] = rd; m_wr[m] = wr;
    m_ref[m] = 0; m_dirty[m] = 0;
  endtask

  task automatic fill(logic [31:0] pa, logic [31:0] d);
    @(negedge clk);
    fill_en = 1; fill_paddr = pa; fill_data = d;
    @(negedge clk);
    fill_en = 0;
    c_v[pa[11:2]] = 1; c_tag[pa[11:2]] = pa[31:12]; c_dat[pa[11:2]] = d;
  endtask

  // expected outcome from the requirements; label chosen by outcome when empty
  task automatic access(bit st, logic [31:0] va, logic [31:0] wd, string lbl);
    int m, idx;
    bit perm, chit;
    logic [69:0] e;
    string r;
    m = find_tlb(va[31:12]);
    idx = int'(va[11:2]);
    if (m < 0) begin
      e = '0; e[68] = 1; r = "R2";
    end else begin
      perm = st ? m_wr[m] : m_rd[m];
      chit = c_v[idx] && c_tag[idx] == m_ppn[m];
      e = {perm && chit, 1'b0, !perm, perm && !chit, m_ref[m], m_dirty[m],
           m_ppn[m], va[11:0], (perm && chit) ? c_dat[idx] : 32'h0};
      r = !perm ? "R5" : (chit ? "R3" : "R4");
    end
    if (lbl != "") r = lbl;
    @(negedge clk);
    check1("R1 ready", req_ready, 1'b1);
    req_valid = 1; req_vaddr = va; req_store = st; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    check1("R1 resp_valid", resp_valid, 1'b1);
    check(r, actual_vec(), e);
    if (m >= 0) begin
      m_ref[m] = 1;
      if (st && perm) m_dirty[m] = 1;
      if (st && perm && chit) c_dat[idx] = wd;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [69:0] snap;
    logic [19:0] va_a, va_b, pp;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 12; i++) vpn_pool[i] = 20'h00100 + 20'(i * 37);
    for (int i = 0; i < 5; i++)  ppn_pool[i] = 20'hA0000 + 20'(i * 11);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check1("R1 reset resp_valid", resp_valid, 1'b0);
    check1("R1 reset ready", req_ready, 1'b1);

    va_a = 20'h12345; va_b = 20'h0BEEF; pp = 20'hC0DE0;
    access(0, {va_a, 12'h3A4}, 0, "R2 empty");
    tlb_write(va_a, pp, 1, 1);
    access(0, {va_a, 12'h3A4}, 0, "R4 R6 first");
    fill({pp, 12'h3A4}, 32'hDEAD_0001);
    access(0, {va_a, 12'h3A7}, 0, "R3 R6 ref");
    access(1, {va_a, 12'h3A4}, 32'h0BAD_CAFE, "R8 R7 store");
    access(0, {va_a, 12'h3A4}, 0, "R8 R7 dirty");
    fill({ppn_pool[0], 12'h3A4}, 32'h1111_2222);
    access(0, {va_a, 12'h3A4}, 0, "R4 foreign tag");
    fill({pp, 12'h3A4}, 32'h5555_AAAA);
    tlb_write(va_b, pp, 1, 0);
    access(1, {va_b, 12'h3A4}, 32'hFFFF_0000, "R5 R7 fault");
    access(0, {va_b, 12'h3A4}, 0, "R11 R8 alias");
    access(0, {va_b, 12'h3A4}, 0, "R7 no dirty");
    access(0, {va_b, 12'h000}, 0, "R5 R4 load ok");
    tlb_write(va_b, pp, 0, 1);
    access(0, {va_b, 12'h3A4}, 0, "R9 R5 rewrite");
    access(1, {va_b, 12'h3A4}, 32'h7777_8888, "R9 store ok");
    for (int i = 0; i < 7; i++) tlb_write(vpn_pool[i], ppn_pool[i % 5], 1, 1);
    access(0, {va_a, 12'h3A4}, 0, "R9 evicted");
    access(0, {va_b, 12'h3A4}, 0, "R9 survivor");

    // back-pressure
    resp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = {va_b, 12'h3A4}; req_store = 0;
    @(negedge clk);
    req_valid = 0;
    snap = actual_vec();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check1("R1 stall valid", resp_valid, 1'b1);
      check1("R1 stall ready", req_ready, 1'b0);
      check("R1 stall hold", actual_vec(), snap);
    end
    resp_ready = 1;
    @(negedge clk);
    check1("R1 drained", resp_valid, 1'b0);
    m_ref[find_tlb(va_b)] = 1;

    // reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model_reset();
    access(0, {va_b, 12'h3A4}, 0, "R10 tlb cleared");
    tlb_write(va_b, pp, 1, 1);
    access(0, {va_b, 12'h3A4}, 0, "R10 lines cleared");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [31:0] va;
      r = $urandom % 10;
      va = {vpn_pool[$urandom % 12], 10'(($urandom % 8) * 5), 2'($urandom)};
      if (r < 2)
        tlb_write(vpn_pool[$urandom % 12], ppn_pool[$urandom % 5],
                  ($urandom % 5) != 0, ($urandom % 2) != 0);
      else if (r < 4)
        fill({ppn_pool[$urandom % 5], 10'(($urandom % 8) * 5), 2'b00}, $urandom);
      else
        access(($urandom % 3) == 0, va, $urandom, "");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule